// File: doc/BRIEF.md
# Host Download Command Port Controller

This block interprets single-byte host writes aimed at one fixed offset of a control register window as a small command protocol. The protocol loads resource data into an internal RAM. The same offset carries command bytes, the two start-address bytes and the payload. What a byte means depends only on the current protocol state.

A session follows a fixed order:

1. The host issues the jump-to-ROM byte, which arms the port.
2. The host issues the download byte.
3. The host writes the 16-bit start address, low byte first.
4. Every later byte is written to RAM at an address that advances by one after each write.
5. A terminate byte closes the session, and the port returns to the unarmed idle state.

The RAM write port is registered. Two status outputs show whether the port is armed and whether a download is in progress. The RAM itself and any firmware execution are outside this block.

Top module: `dlport_ctrl`

## Requirements
- R1: After synchronous reset, `armed`, `busy` and `ram_we` are all low.
- R2: A write affects the protocol only when `wr_en` is high and `wr_ofs` equals 5. Writes to any other offset change no state and produce no RAM write.
- R3: Byte 57h at offset 5 while unarmed raises `armed` in the next cycle. Every other byte leaves the port unarmed.
- R4: Byte AAh while unarmed is ignored, so `busy` stays low.
- R5: Byte AAh while armed and not downloading raises `busy` in the next cycle. The next two offset-5 bytes are taken literally as the low and then the high start-address byte, even when they equal a command value.
- R6: Each later offset-5 byte other than 79h produces a one-cycle `ram_we` pulse in the next cycle. In that cycle `ram_data` is the byte and `ram_addr` is the start address plus the byte's index, wrapping modulo 2^16.
- R7: Byte 79h during the payload phase writes nothing and drops both `busy` and `armed` in the next cycle. A new download then needs 57h again, and AAh alone is ignored.
- R8: While armed, a repeated 57h has no effect. During the payload phase, 57h and AAh are ordinary data bytes.
- R9: Reset in the middle of a download aborts it. Later data bytes are not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte-write strobe, one cycle per byte |
| wr_ofs | input | 4 | Offset within the control window |
| wr_data | input | 8 | Written byte |
| ram_we | output | 1 | RAM write enable, one cycle per payload byte |
| ram_addr | output | 16 | RAM write address |
| ram_data | output | 8 | RAM write data |
| armed | output | 1 | Jump-to-ROM accepted and session not yet ended |
| busy | output | 1 | High from the download byte until the session ends |

## Verification
The assertions assume that `wr_en`, `wr_ofs` and `wr_data` hold known values at every rising edge after reset. They also assume that at most one byte arrives per cycle, and that reset is held for at least one edge. The stimulus changes these inputs only on falling edges and never leaves them undriven. It sweeps every byte value and every offset while the port is idle. It walks start addresses that include the top of the address space and addresses whose bytes equal the command codes.

// File: rtl/dlport_pkg.sv
package dlport_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_STREAM
    } dl_state_e;

    typedef struct packed {
        logic              hit;
        logic              is_jump;
        logic              is_dl;
        logic              is_term;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    function automatic logic [ADDR_W-1:0] join_addr(input logic [BYTE_W-1:0] lo,
                                                    input logic [BYTE_W-1:0] hi);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/dlport_decode.sv
module dlport_decode
    import dlport_pkg::*;
#(
    parameter int              OFS_W    = 4,
    parameter int              CMD_OFS  = 5,
    parameter logic [BYTE_W-1:0] JUMP_CMD = 8'h57,
    parameter logic [BYTE_W-1:0] DL_CMD   = 8'hAA,
    parameter logic [BYTE_W-1:0] TERM_CMD = 8'h79
) (
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [BYTE_W-1:0] wr_data,
    output cmd_t              cmd
);
    localparam logic [OFS_W-1:0] PORT_OFS = OFS_W'(CMD_OFS);

    always_comb begin
        cmd.hit     = wr_en && (wr_ofs == PORT_OFS);
        cmd.is_jump = (wr_data == JUMP_CMD);
        cmd.is_dl   = (wr_data == DL_CMD);
        cmd.is_term = (wr_data == TERM_CMD);
        cmd.data    = wr_data;
    end
endmodule

// File: rtl/dlport_fsm.sv
module dlport_fsm
    import dlport_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    output logic load_lo,
    output logic load_hi,
    output logic push,
    output logic busy_o,
    output logic armed_o
);
    dl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd.hit && cmd.is_jump) state_d = ST_ARMED;
            ST_ARMED:   if (cmd.hit && cmd.is_dl)   state_d = ST_ADDR_LO;
            ST_ADDR_LO: if (cmd.hit)                state_d = ST_ADDR_HI;
            ST_ADDR_HI: if (cmd.hit)                state_d = ST_STREAM;
            ST_STREAM:  if (cmd.hit && cmd.is_term) state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        load_lo = (state_q == ST_ADDR_LO) && cmd.hit;
        load_hi = (state_q == ST_ADDR_HI) && cmd.hit;
        push    = (state_q == ST_STREAM) && cmd.hit && !cmd.is_term;
        busy_o  = (state_q == ST_ADDR_LO) || (state_q == ST_ADDR_HI) ||
                  (state_q == ST_STREAM);
        armed_o = (state_q != ST_IDLE);
    end

    // R2: a byte that misses the command port leaves the state unchanged
    a_r2_stray_write_holds: assert property (@(posedge clk) disable iff (rst)
        !cmd.hit |=> state_q == $past(state_q));

    // R4: from the unarmed state no download can begin
    a_r4_dl_needs_arm: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !busy_o);

    // R5: busy rises only on the download byte while armed
    a_r5_busy_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(state_q == ST_ARMED && cmd.hit && cmd.is_dl));

    // R7: the terminate byte during payload returns to unarmed idle
    a_r7_term_ends: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && cmd.hit && cmd.is_term) |=> !armed_o && !busy_o);
endmodule

// File: rtl/dlport_addr.sv
module dlport_addr
    import dlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              push,
    input  logic [BYTE_W-1:0] data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_data
);
    logic [BYTE_W-1:0] lo_q;
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
            lo_q     <= '0;
            ptr_q    <= '0;
        end else begin
            ram_we <= push;
            if (load_lo) lo_q  <= data;
            if (load_hi) ptr_q <= join_addr(lo_q, data);
            if (push) begin
                ram_addr <= ptr_q;
                ram_data <= data;
                ptr_q    <= ptr_q + 1'b1;
            end
        end
    end

    // R6: back-to-back payload writes land on consecutive addresses
    a_r6_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> ram_addr == $past(ram_addr) + 1'b1);
endmodule

// File: rtl/dlport_ctrl.sv
module dlport_ctrl
    import dlport_pkg::*;
#(
    parameter int              OFS_W    = 4,
    parameter int              CMD_OFS  = 5,
    parameter logic [7:0]      JUMP_CMD = 8'h57,
    parameter logic [7:0]      DL_CMD   = 8'hAA,
    parameter logic [7:0]      TERM_CMD = 8'h79
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [7:0]        wr_data,
    output logic              ram_we,
    output logic [15:0]       ram_addr,
    output logic [7:0]        ram_data,
    output logic              armed,
    output logic              busy
);
    cmd_t cmd;
    logic load_lo, load_hi, push;

    dlport_decode #(
        .OFS_W(OFS_W), .CMD_OFS(CMD_OFS),
        .JUMP_CMD(JUMP_CMD), .DL_CMD(DL_CMD), .TERM_CMD(TERM_CMD)
    ) u_decode (
        .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data), .cmd(cmd)
    );

    dlport_fsm u_fsm (
        .clk(clk), .rst(rst), .cmd(cmd),
        .load_lo(load_lo), .load_hi(load_hi), .push(push),
        .busy_o(busy), .armed_o(armed)
    );

    dlport_addr u_addr (
        .clk(clk), .rst(rst),
        .load_lo(load_lo), .load_hi(load_hi), .push(push), .data(cmd.data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data)
    );

    // R6: a RAM write only follows a cycle in which a download was open
    a_r6_we_while_busy: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(busy));

    // R5: a download in progress implies the port is armed
    a_r5_busy_armed: assert property (@(posedge clk) disable iff (rst)
        busy |-> armed);
endmodule

// File: tb/dlport_ctrl_tb.sv
module dlport_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_ofs = '0;
    logic [7:0]  wr_data = '0;
    logic        ram_we, armed, busy;
    logic [15:0] ram_addr;
    logic [7:0]  ram_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlport_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data),
        .armed(armed), .busy(busy)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one byte at a falling edge; returns at the next falling edge
    task automatic put(input logic [3:0] o, input logic [7:0] d);
        wr_en = 1'b1; wr_ofs = o; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic open_dl(input logic [15:0] start);
        put(4'd5, 8'h57);
        chk(armed, "R3 arm", {31'd0, armed}, 1);
        put(4'd5, 8'hAA);
        chk(busy, "R5 busy on download", {31'd0, busy}, 1);
        put(4'd5, start[7:0]);
        put(4'd5, start[15:8]);
    endtask

    task automatic stream(input logic [15:0] start, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0]  d;
            logic [15:0] ea;
            d  = seed + 8'(i * 13);
            if (d == 8'h79) d = 8'h80;
            ea = start + 16'(i);
            put(4'd5, d);
            chk(ram_we, "R6 we", {31'd0, ram_we}, 1);
            chk(ram_addr == ea, "R6 addr", {16'd0, ram_addr}, {16'd0, ea});
            chk(ram_data == d, "R6 data", {24'd0, ram_data}, {24'd0, d});
        end
        put(4'd5, 8'h79);
        chk(!ram_we, "R7 no write on term", {31'd0, ram_we}, 0);
        chk(!busy && !armed, "R7 end", {30'd0, busy, armed}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL ALL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!armed && !busy && !ram_we, "R1 reset state", {29'd0, armed, busy, ram_we}, 0);

        // R2: jump byte at every other offset is ignored
        for (int o = 0; o < 16; o++) begin
            if (o == 5) continue;
            put(4'(o), 8'h57);
            chk(!armed, "R2 other offset", {31'd0, armed}, 0);
        end
        // R3 / R4: every non-jump byte while idle leaves the port unarmed
        for (int b = 0; b < 256; b++) begin
            if (b == 8'h57) continue;
            put(4'd5, 8'(b));
            chk(!armed && !busy && !ram_we, (b == 8'hAA) ? "R4 early download" : "R3 non-jump",
                {29'd0, armed, busy, ram_we}, 0);
        end

        // R8: repeated jump while armed
        put(4'd5, 8'h57);
        chk(armed, "R3 arm", {31'd0, armed}, 1);
        put(4'd5, 8'h57);
        chk(armed && !busy, "R8 repeat jump", {30'd0, armed, busy}, 2);
        put(4'd5, 8'hAA);
        chk(busy, "R5 busy", {31'd0, busy}, 1);
        // R5 / R2: address bytes equal to command values, strays in between
        put(4'd2, 8'h11);
        put(4'd5, 8'hAA);
        put(4'd7, 8'h22);
        put(4'd5, 8'h79);
        chk(busy && !ram_we, "R5 literal address", {30'd0, busy, ram_we}, 2);
        stream(16'h79AA, 8, 8'h05);

        // R6: several start addresses including wrap at the top
        open_dl(16'h4000); stream(16'h4000, 20, 8'h01);
        open_dl(16'h0000); stream(16'h0000, 12, 8'h33);
        open_dl(16'hFFFE); stream(16'hFFFE, 6, 8'hC0);
        open_dl(16'h1234); stream(16'h1234, 16, 8'h9D);

        // R2 / R8: stray writes and command values inside the payload
        open_dl(16'h0100);
        put(4'd5, 8'h01);
        chk(ram_addr == 16'h0100, "R6 addr", {16'd0, ram_addr}, 32'h100);
        put(4'd4, 8'h02);
        chk(!ram_we, "R2 stray in payload", {31'd0, ram_we}, 0);
        put(4'd5, 8'hAA);
        chk(ram_we && ram_addr == 16'h0101 && ram_data == 8'hAA, "R8 AA as data",
            {7'd0, ram_we, ram_addr, ram_data}, {7'd0, 1'b1, 16'h0101, 8'hAA});
        put(4'd5, 8'h57);
        chk(ram_we && ram_addr == 16'h0102 && ram_data == 8'h57, "R8 57 as data",
            {7'd0, ram_we, ram_addr, ram_data}, {7'd0, 1'b1, 16'h0102, 8'h57});
        put(4'd5, 8'h79);
        chk(!busy && !armed, "R7 end", {30'd0, busy, armed}, 0);
        // R7: download byte alone after termination is ignored
        put(4'd5, 8'hAA);
        chk(!busy, "R7 needs rearm", {31'd0, busy}, 0);

        // R9: reset mid-download
        open_dl(16'h2000);
        put(4'd5, 8'h03);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !armed && !ram_we, "R9 abort", {29'd0, armed, busy, ram_we}, 0);
        put(4'd5, 8'h09);
        chk(!ram_we, "R9 no write after abort", {31'd0, ram_we}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule